// File: doc/BRIEF.md
# Slow Clock Source Selector

The block produces the low-speed timebase of a chip as a one-cycle enable pulse in the main clock domain. The pulse comes from one of two sources. The first is a divided main clock: a programmable 8-bit prescale count followed by a fixed halving stage, which gives divisors from 2 to 512. The second is a free-running low-frequency oscillator that reaches the block as an asynchronous input. After reset the divided main clock is always the source, so a slow timebase exists before software has done anything.

Software asks for the oscillator through a request input. The request is granted only while an activity monitor sees the synchronized oscillator toggling within a programmable window of main-clock cycles. The change of source is made only at the end of a slow period of the source being left. While the oscillator drives the timebase, the prescaler is held idle. If the oscillator stops while it is in use, the block falls back to the divided clock at once. It then raises a loss flag that stays set until the request is withdrawn.

Top module: `slowclk_selector`

## Requirements
- R1: With the divided source active and prescale value N on `prescale_n`, `slow_en` pulses for one cycle every 2×(N+1) main-clock cycles. Two pulses are never adjacent.
- R2: During and directly after reset, `src_is_osc`=0, `osc_active`=0 and `osc_lost`=0, and the divided main clock is the source.
- R3: While `src_is_osc`=1, `slow_en` pulses exactly once per rising edge of the synchronized oscillator. The prescaler contributes no pulses, so the pulse spacing equals the oscillator period.
- R4: While `osc_active`=0, `use_osc_req`=1 has no effect. `src_is_osc` stays 0 and the divided-clock pulse spacing stays 2×(N+1).
- R5: `osc_active` rises after any oscillator edge passes the two-stage synchronizer. It falls when `act_window` main-clock cycles pass with no edge. A larger window delays the fall by exactly the difference in window values.
- R6: `src_is_osc` rises only in the cycle after a divided-clock pulse, and only while `use_osc_req`=1 and `osc_active`=1.
- R7: With the oscillator selected and `use_osc_req` dropped to 0, `src_is_osc` falls in the cycle after an oscillator pulse. The next pulse follows a full 2×(N+1) cycles after that oscillator pulse.
- R8: If `osc_active` falls while the oscillator is selected, `src_is_osc` returns to 0 on the next cycle and `osc_lost` becomes 1. Divided-clock pulses then resume with 2×(N+1) spacing.
- R9: `osc_lost` stays 1 while `use_osc_req`=1. It clears one cycle after `use_osc_req` is 0 while the divided source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 1 | Low-frequency oscillator, asynchronous to clk |
| use_osc_req | input | 1 | Software request to run from the oscillator |
| prescale_n | input | 8 | Prescale value N; divisor is 2×(N+1) |
| act_window | input | 16 | Edge-free main-clock cycles before the oscillator is flagged inactive |
| slow_en | output | 1 | One-cycle slow timebase pulse |
| src_is_osc | output | 1 | 1 when the oscillator is the current source |
| osc_active | output | 1 | 1 while oscillator toggling is detected |
| osc_lost | output | 1 | Sticky flag set on fallback after loss of the oscillator |

## Verification
`slow_en` is combinational from registered state, so it is valid in the same cycle as the counter state that causes it. `src_is_osc` and `osc_lost` change one edge after the pulse or the activity drop that triggers them. The bench therefore samples everything on the falling edge. It measures pulse spacing as a count of falling edges between two pulses, and it checks each source change against the pulse value sampled one cycle earlier. An oscillator edge reaches `osc_active` three edges after the input changes, and the idle fall comes about `act_window`+3 edges after the last edge. Because of that synchronizer offset, the bench checks the window behaviour as an exact difference between two window settings plus a narrow absolute range.

// File: rtl/slowclk_pkg.sv
// Shared types for the slow clock source selector.
package slowclk_pkg;
    typedef enum logic {
        SRC_PRESC = 1'b0,
        SRC_OSC   = 1'b1
    } slow_src_e;
endpackage

// File: rtl/slowclk_presc.sv
// Divided main-clock timebase: a prescale counter (0..N) feeding a halving
// stage. Emits one tick every 2*(N+1) enabled cycles. When en is low the
// counter and halving flop are held at zero, so after re-enable the first
// tick comes a full period later.
// Assumes: div_sel may change at any time; the counter wraps on >= so a
// smaller value never leaves the counter running past it.
module slowclk_presc #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PRESC_W-1:0] div_sel,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt_q;
    logic               half_q;
    logic               wrap;

    assign wrap = (cnt_q >= div_sel);
    assign tick = en && wrap && half_q;

    // Count the prescale phase and toggle the halving stage at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            half_q <= ~half_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/slowclk_act_det.sv
// Oscillator activity monitor: brings osc_in into the clk domain through a
// synchronizer chain, finds edges of either polarity and rising edges, and
// keeps a window counter. Any edge sets active. Reaching win_limit cycles
// without an edge clears it.
// Assumes: osc_in is much slower than clk; reset value of osc_in is ignored.
module slowclk_act_det #(
    parameter int WIN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_in,
    input  logic [WIN_W-1:0] win_limit,
    output logic             osc_rise,
    output logic             active
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic [WIN_W-1:0]   idle_q;
    logic               any_edge;

    assign any_edge = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];
    assign osc_rise = chain_q[CHAIN_W-2] && !chain_q[CHAIN_W-1];

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], osc_in};
    end

    // Idle window counter and the activity flag it drives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
            active <= 1'b0;
        end else if (any_edge) begin
            idle_q <= '0;
            active <= 1'b1;
        end else if (idle_q >= win_limit) begin
            active <= 1'b0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R5
    active_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(any_edge));
    // R5
    active_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !$past(any_edge));
endmodule

// File: rtl/slowclk_src_ctl.sv
// Source controller: holds the selected source. It moves to the oscillator
// only at a divided-clock tick with request and activity present, and back
// at an oscillator tick when the request is dropped. On loss of activity it
// returns at once and sets a sticky loss flag, which the request's removal
// clears. It also gates the prescaler.
// Assumes: presc_tick and osc_rise are single-cycle pulses in clk domain.
module slowclk_src_ctl
    import slowclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  logic      active,
    input  logic      osc_rise,
    input  logic      presc_tick,
    output slow_src_e src,
    output logic      lost,
    output logic      presc_en
);
    logic is_osc;

    assign is_osc   = (src == SRC_OSC);
    assign presc_en = !is_osc;

    // Source state and loss flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src  <= SRC_PRESC;
            lost <= 1'b0;
        end else begin
            unique case (src)
                SRC_PRESC: begin
                    if (!req) lost <= 1'b0;
                    if (presc_tick && req && active) src <= SRC_OSC;
                end
                SRC_OSC: begin
                    if (!active) begin
                        src  <= SRC_PRESC;
                        lost <= 1'b1;
                    end else if (osc_rise && !req) begin
                        src <= SRC_PRESC;
                    end
                end
                default: src <= SRC_PRESC;
            endcase
        end
    end

    // R2
    reset_src_chk: assert property (@(posedge clk)
        !rst_n |=> (src == SRC_PRESC && !lost));
    // R3
    presc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_osc |-> !presc_tick);
    // R6
    switch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_osc) |-> $past(presc_tick && req && active));
    // R7
    return_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(is_osc) |-> $past(!active || (osc_rise && !req)));
    // R8
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_osc && !active) |=> (!is_osc && lost));
    // R9
    lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !is_osc) |=> !lost);
endmodule

// File: rtl/slowclk_selector.sv
// Slow clock source selector top: ties the prescaler, the oscillator
// activity monitor and the source controller together, and muxes the
// chosen tick onto slow_en.
// Assumes: all outputs are in the clk domain; slow_en is a clock enable.
module slowclk_selector
    import slowclk_pkg::*;
#(
    parameter int PRESC_W     = 8,
    parameter int WIN_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_in,
    input  logic               use_osc_req,
    input  logic [PRESC_W-1:0] prescale_n,
    input  logic [WIN_W-1:0]   act_window,
    output logic               slow_en,
    output logic               src_is_osc,
    output logic               osc_active,
    output logic               osc_lost
);
    logic      presc_tick;
    logic      presc_en;
    logic      osc_rise;
    slow_src_e src;

    slowclk_presc #(.PRESC_W(PRESC_W)) presc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (presc_en),
        .div_sel (prescale_n),
        .tick    (presc_tick)
    );

    slowclk_act_det #(.WIN_W(WIN_W), .SYNC_STAGES(SYNC_STAGES)) act_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_in    (osc_in),
        .win_limit (act_window),
        .osc_rise  (osc_rise),
        .active    (osc_active)
    );

    slowclk_src_ctl ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (use_osc_req),
        .active     (osc_active),
        .osc_rise   (osc_rise),
        .presc_tick (presc_tick),
        .src        (src),
        .lost       (osc_lost),
        .presc_en   (presc_en)
    );

    // Route the tick of the selected source to the timebase output.
    always_comb begin
        src_is_osc = (src == SRC_OSC);
        slow_en    = src_is_osc ? osc_rise : presc_tick;
    end
endmodule

// File: tb/slowclk_selector_tb.sv
`timescale 1ns/1ps
module slowclk_selector_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_in = 1'b0;
    logic        use_osc_req = 1'b0;
    logic [7:0]  prescale_n = 8'd5;
    logic [15:0] act_window = 16'd30;
    logic        slow_en, src_is_osc, osc_active, osc_lost;

    int  total = 0;
    int  bad = 0;
    int  cycles = 0;
    bit  osc_run = 1'b0;
    bit  prev_src = 1'b0;
    bit  prev_en = 1'b0;

    slowclk_selector dut_i (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .use_osc_req(use_osc_req),
        .prescale_n(prescale_n), .act_window(act_window), .slow_en(slow_en),
        .src_is_osc(src_is_osc), .osc_active(osc_active), .osc_lost(osc_lost)
    );

    always #2.5 clk = ~clk;

    // Oscillator model: 100 ns half period (20 main cycles), off the clock edges.
    always begin
        #100;
        if (osc_run) osc_in = ~osc_in;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Boundary monitor: a source change with activity present must follow a pulse (R6, R7).
    always @(negedge clk) begin
        cycles++;
        if (rst_n && src_is_osc != prev_src && osc_active)
            chk(prev_en, "R6/R7 source change off a period boundary", 0, 1);
        prev_src = src_is_osc;
        prev_en  = slow_en;
    end

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        chk(1'b0, "watchdog expired", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic wait_pulse(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (slow_en) begin seen = 1'b1; break; end
        end
    endtask

    task automatic measure_gap(output int gap);
        bit seen;
        gap = -1;
        wait_pulse(seen);
        if (!seen) return;
        for (int i = 1; i < 3000; i++) begin
            @(negedge clk);
            if (slow_en) begin gap = i; break; end
        end
    endtask

    task automatic wait_src(input bit val, input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (src_is_osc == val) begin n = i; break; end
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(src_is_osc == 0, "R2 src during reset", src_is_osc, 0);
        chk(osc_active == 0, "R2 active during reset", osc_active, 0);
        chk(osc_lost == 0, "R2 lost during reset", osc_lost, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(src_is_osc == 0 && osc_lost == 0, "R2 state after reset", src_is_osc, 0);
    endtask

    task automatic t_divisors();
        int gap;
        int nv [3] = '{0, 5, 255};
        for (int k = 0; k < 3; k++) begin
            bit seen;
            prescale_n = nv[k][7:0];
            wait_pulse(seen);
            measure_gap(gap);
            chk(gap == 2 * (nv[k] + 1), "R1 divided period", gap, 2 * (nv[k] + 1));
        end
        prescale_n = 8'd2;
    endtask

    task automatic t_no_activity();
        int gap;
        use_osc_req = 1'b1;
        repeat (300) @(negedge clk);
        chk(src_is_osc == 0, "R4 request ignored without activity", src_is_osc, 0);
        chk(osc_active == 0, "R5 no activity without edges", osc_active, 0);
        measure_gap(gap);
        chk(gap == 6, "R4 divided period kept", gap, 6);
    endtask

    task automatic t_switch_to_osc();
        int n, gap;
        osc_run = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (osc_active) break;
        end
        chk(osc_active == 1, "R5 activity detected", osc_active, 1);
        wait_src(1'b1, 200, n);
        chk(n > 0, "R6 switched to oscillator", src_is_osc, 1);
        measure_gap(gap);
        chk(gap == 40, "R3 oscillator pulse spacing", gap, 40);
        measure_gap(gap);
        chk(gap == 40, "R3 prescaler idle while oscillator selected", gap, 40);
    endtask

    task automatic t_req_drop();
        int gap;
        bit seen;
        use_osc_req = 1'b0;
        wait_pulse(seen);
        for (int i = 1; i < 3000; i++) begin
            @(negedge clk);
            if (slow_en) begin gap = i; break; end
        end
        chk(src_is_osc == 0, "R7 returned to divided clock", src_is_osc, 0);
        chk(gap == 6, "R7 full first divided period", gap, 6);
        chk(osc_lost == 0, "R7 no loss flag on requested return", osc_lost, 0);
    endtask

    task automatic t_loss();
        int n, gap;
        use_osc_req = 1'b1;
        wait_src(1'b1, 200, n);
        chk(n > 0, "R6 reselected oscillator", src_is_osc, 1);
        osc_run = 1'b0;
        wait_src(1'b0, 300, n);
        chk(n > 0, "R8 fallback on loss", src_is_osc, 0);
        chk(osc_lost == 1, "R8 loss flag set", osc_lost, 1);
        chk(osc_active == 0, "R8 activity cleared", osc_active, 0);
        measure_gap(gap);
        chk(gap == 6, "R8 divided pulses resume", gap, 6);
        repeat (50) @(negedge clk);
        chk(osc_lost == 1, "R9 loss flag held under request", osc_lost, 1);
        use_osc_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(osc_lost == 0, "R9 loss flag cleared", osc_lost, 0);
    endtask

    task automatic one_edge_life(input int w, output int n);
        bit up = 1'b0;
        act_window = w[15:0];
        repeat (w + 10) @(negedge clk);
        @(posedge clk);
        #1 osc_in = ~osc_in;
        n = -1;
        for (int i = 1; i < 500; i++) begin
            @(negedge clk);
            if (osc_active) up = 1'b1;
            if (up && !osc_active) begin n = i; break; end
        end
    endtask

    task automatic t_window();
        int n30, n60;
        one_edge_life(30, n30);
        one_edge_life(60, n60);
        chk(n30 >= 33 && n30 <= 36, "R5 inactive after window", n30, 35);
        chk(n60 - n30 == 30, "R5 window difference", n60 - n30, 30);
        chk(src_is_osc == 0, "R4 no switch on lone edges without request", src_is_osc, 0);
    endtask

    initial begin
        t_reset();
        t_divisors();
        t_no_activity();
        t_switch_to_osc();
        t_req_drop();
        t_loss();
        t_window();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule